// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block decides which fault-confinement mode a CAN node is in, using the receive and transmit error counts that the protocol engine keeps elsewhere. A node with both counts low is error-active. It becomes error-passive once either count gets high. It is removed from the bus (bus-off) once the transmit count overflows its 8-bit range. The block also keeps a warning flag and a passive status bit for each counter. It emits masked single-cycle event pulses that interrupt logic can latch.

While the node is bus-off, the block watches the sampled bus level on each bit-time strobe. It counts runs of eleven consecutive recessive samples. After 128 such runs it asks for the external error counters to be cleared for one cycle, then reports error-active again. A hold input can keep the node in bus-off after the sequence is complete, so the host decides when to rejoin.

Top module: `can_fault_confine`

## Requirements
- R1: During and right after reset, `mode` is 2'b00 (error-active). `warnFlag`, `txPassive`, `rxPassive`, `evtPulse` and `clearCounters` are all 0.
- R2: Outside bus-off, when both counts were below 128 and the transmit count was below 256 at a clock edge, `mode` reads 2'b00 after that edge.
- R3: Outside bus-off, when either count was 128 or more and the transmit count was below 256 at an edge, `mode` reads 2'b01 after that edge.
- R4: A transmit count of 256 or more at an edge outside bus-off makes `mode` read 2'b10 after that edge. A receive count alone never causes 2'b10, even at 256 or above.
- R5: Once bus-off, `mode` stays 2'b10 whatever the counts are. The block counts samples only on cycles with `bitStrobe` high. A dominant sample (`busRecessive`=0) restarts the current run. Eleven recessive samples complete one run. Recovery needs 128 completed runs.
- R6: When recovery completes with `recoverHold` low, `clearCounters` is high for exactly one cycle while `mode` still reads 2'b10, and `mode` reads 2'b00 in the next cycle.
- R7: While `recoverHold` is high, a completed recovery does not leave bus-off and `clearCounters` stays 0. Dropping the hold starts the R6 sequence at the next edge.
- R8: `warnFlag` follows, one cycle later, whether either count is 96 or more. It is 0 only when both counts were below 96.
- R9: `txPassive` and `rxPassive` follow, one cycle later, whether the transmit and receive counts respectively are 128 or more.
- R10: `evtPulse` bit 0 marks transmit warning, bit 1 receive warning, bit 2 transmit passive and bit 3 receive passive. Each bit is a one-cycle pulse one cycle after its condition rises, and never repeats while the condition stays true.
- R11: A pulse appears only if the matching `evtEnable` bit was high at the edge where the condition rose. A masked rise produces no pulse.
- R12: `evtPulse` bit 4 pulses for one cycle in the same cycle that `mode` first reads 2'b10 on entering bus-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxErrCnt | input | 9 | Receive error count |
| txErrCnt | input | 9 | Transmit error count |
| bitStrobe | input | 1 | One cycle per bit time, qualifies busRecessive |
| busRecessive | input | 1 | Sampled bus level, 1 = recessive |
| recoverHold | input | 1 | Keeps the node in bus-off after recovery completes |
| evtEnable | input | 5 | Per-event enables, bit order as evtPulse |
| mode | output | 2 | 00 error-active, 01 error-passive, 10 bus-off |
| warnFlag | output | 1 | Either count at or above 96 |
| txPassive | output | 1 | Transmit count at or above 128 |
| rxPassive | output | 1 | Receive count at or above 128 |
| evtPulse | output | 5 | Event pulses: tx warn, rx warn, tx passive, rx passive, bus-off entry |
| clearCounters | output | 1 | One-cycle request to zero the external error counters |

## Verification
The assertions assume that the counts, strobe, bus level, hold and enables are steady around each rising edge. They do not assume that the counts change in any particular order or step size. Because bus-off deliberately ignores the counts, the stimulus is allowed to keep driving arbitrary counts during recovery. The stimulus drives every input on the falling edge. It draws counts from bands that straddle 96, 128 and 256. It keeps strobe and bus level random during bus-off so that runs are broken at varied points, and it only zeroes the counts after the clear request appears.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_PASSIVE = 2'b01,
    ST_BUSOFF  = 2'b10,
    ST_RECOVER = 2'b11
  } fcState_e;

  localparam int EVT_N = 5;

  // level conditions from the datapath, bit order matches evtPulse[3:0]
  typedef struct packed {
    logic overLimit;
    logic rxPas;
    logic txPas;
    logic rxWarn;
    logic txWarn;
  } fcCond_t;

  // strobes from control to datapath
  typedef struct packed {
    logic seqRun;
    logic seqClear;
  } fcStrobe_t;
endpackage

// File: rtl/fc_datapath.sv
module fc_datapath import fc_pkg::*; #(
  parameter int CNT_W      = 9,
  parameter int WARN_LIM   = 96,
  parameter int PASS_LIM   = 128,
  parameter int OFF_LIM    = 256,
  parameter int RUN_LEN    = 11,
  parameter int OCC_TARGET = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] rxErrCnt,
  input  logic [CNT_W-1:0] txErrCnt,
  input  logic             bitStrobe,
  input  logic             busRecessive,
  input  fcStrobe_t        strobe,
  output fcCond_t          cond,
  output logic             seqDone
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam int OCC_W = $clog2(OCC_TARGET + 1);
  localparam int CMP_W = CNT_W + 2;

  logic [1:0] warnHit, passHit;
  logic [CNT_W-1:0] cntArr [2];
  assign cntArr[0] = txErrCnt;
  assign cntArr[1] = rxErrCnt;

  for (genvar g = 0; g < 2; g++) begin : gCmp
    assign warnHit[g] = CMP_W'(cntArr[g]) >= CMP_W'(WARN_LIM);
    assign passHit[g] = CMP_W'(cntArr[g]) >= CMP_W'(PASS_LIM);
  end

  assign cond.txWarn    = warnHit[0];
  assign cond.rxWarn    = warnHit[1];
  assign cond.txPas     = passHit[0];
  assign cond.rxPas     = passHit[1];
  assign cond.overLimit = CMP_W'(txErrCnt) >= CMP_W'(OFF_LIM);

  logic [RUN_W-1:0] runQ;
  logic [OCC_W-1:0] occQ;
  logic             runEnd;

  assign runEnd  = runQ == RUN_W'(RUN_LEN - 1);
  assign seqDone = occQ == OCC_W'(OCC_TARGET);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.seqClear) begin
      runQ <= '0;
      occQ <= '0;
    end else if (strobe.seqRun && bitStrobe) begin
      if (!busRecessive) begin
        runQ <= '0;
      end else if (runEnd) begin
        runQ <= '0;
        if (!seqDone) occQ <= occQ + 1'b1;
      end else begin
        runQ <= runQ + 1'b1;
      end
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    runQ < RUN_W'(RUN_LEN)); // R5
  AST_OCC_SAT: assert property (@(posedge clk) disable iff (!rstN)
    occQ <= OCC_W'(OCC_TARGET)); // R5
  AST_DOMINANT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.seqRun && !strobe.seqClear && bitStrobe && !busRecessive) |=> runQ == '0); // R5
endmodule

// File: rtl/fc_control.sv
module fc_control import fc_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  fcCond_t          cond,
  input  logic             seqDone,
  input  logic             recoverHold,
  input  logic [EVT_N-1:0] evtEnable,
  output fcStrobe_t        strobe,
  output logic [1:0]       mode,
  output logic             warnFlag,
  output logic             txPassive,
  output logic             rxPassive,
  output logic [EVT_N-1:0] evtPulse,
  output logic             clearCounters
);
  fcState_e stateQ, stateD;
  logic [3:0] prevQ;
  logic [3:0] lvl;

  assign lvl = {cond.rxPas, cond.txPas, cond.rxWarn, cond.txWarn};

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_ACTIVE, ST_PASSIVE: begin
        if (cond.overLimit)                stateD = ST_BUSOFF;
        else if (cond.txPas || cond.rxPas) stateD = ST_PASSIVE;
        else                               stateD = ST_ACTIVE;
      end
      ST_BUSOFF:  if (seqDone && !recoverHold) stateD = ST_RECOVER;
      ST_RECOVER: stateD = ST_ACTIVE;
      default:    stateD = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_ACTIVE;
      prevQ     <= '0;
      evtPulse  <= '0;
      warnFlag  <= 1'b0;
      txPassive <= 1'b0;
      rxPassive <= 1'b0;
    end else begin
      stateQ        <= stateD;
      prevQ         <= lvl;
      evtPulse[3:0] <= lvl & ~prevQ & evtEnable[3:0];
      evtPulse[4]   <= evtEnable[4] && stateD == ST_BUSOFF && stateQ != ST_BUSOFF;
      warnFlag      <= cond.txWarn || cond.rxWarn;
      txPassive     <= cond.txPas;
      rxPassive     <= cond.rxPas;
    end
  end

  assign mode            = (stateQ == ST_RECOVER) ? 2'(ST_BUSOFF) : 2'(stateQ);
  assign clearCounters   = stateQ == ST_RECOVER;
  assign strobe.seqRun   = stateQ == ST_BUSOFF;
  assign strobe.seqClear = stateQ != ST_BUSOFF;

  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    clearCounters |=> !clearCounters); // R6
  AST_CLEAR_THEN_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    clearCounters |=> mode == 2'b00); // R6
  AST_HOLD_KEEPS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_BUSOFF && recoverHold) |=> (mode == 2'b10 && !clearCounters)); // R7
  AST_RX_NO_BUSOFF: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_ACTIVE || stateQ == ST_PASSIVE) && !cond.overLimit) |=> mode != 2'b10); // R4
  AST_PASSIVE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_ACTIVE || stateQ == ST_PASSIVE) && !cond.overLimit && (cond.txPas || cond.rxPas))
      |=> mode == 2'b01); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> (evtPulse & $past(evtPulse)) == '0); // R10
  AST_PULSE_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (evtPulse & ~$past(evtEnable)) == '0); // R11
  AST_OFF_PULSE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse[4] |-> (mode == 2'b10 && !clearCounters)); // R12
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine import fc_pkg::*; #(
  parameter int CNT_W      = 9,
  parameter int WARN_LIM   = 96,
  parameter int PASS_LIM   = 128,
  parameter int OFF_LIM    = 256,
  parameter int RUN_LEN    = 11,
  parameter int OCC_TARGET = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] rxErrCnt,
  input  logic [CNT_W-1:0] txErrCnt,
  input  logic             bitStrobe,
  input  logic             busRecessive,
  input  logic             recoverHold,
  input  logic [4:0]       evtEnable,
  output logic [1:0]       mode,
  output logic             warnFlag,
  output logic             txPassive,
  output logic             rxPassive,
  output logic [4:0]       evtPulse,
  output logic             clearCounters
);
  fcCond_t   cond;
  fcStrobe_t strobe;
  logic      seqDone;

  fc_datapath #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM),
    .OFF_LIM(OFF_LIM), .RUN_LEN(RUN_LEN), .OCC_TARGET(OCC_TARGET)
  ) uDp (
    .clk(clk), .rstN(rstN), .rxErrCnt(rxErrCnt), .txErrCnt(txErrCnt),
    .bitStrobe(bitStrobe), .busRecessive(busRecessive), .strobe(strobe),
    .cond(cond), .seqDone(seqDone)
  );

  fc_control uCtl (
    .clk(clk), .rstN(rstN), .cond(cond), .seqDone(seqDone),
    .recoverHold(recoverHold), .evtEnable(evtEnable), .strobe(strobe),
    .mode(mode), .warnFlag(warnFlag), .txPassive(txPassive),
    .rxPassive(rxPassive), .evtPulse(evtPulse), .clearCounters(clearCounters)
  );
endmodule

// File: tb/sim_can_fault_confine.sv
module sim_can_fault_confine;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] rxErrCnt = '0, txErrCnt = '0;
  logic       bitStrobe = 1'b0, busRecessive = 1'b1, recoverHold = 1'b0;
  logic [4:0] evtEnable = '1;
  logic [1:0] mode;
  logic       warnFlag, txPassive, rxPassive, clearCounters;
  logic [4:0] evtPulse;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  can_fault_confine u0 (
    .clk(clk), .rstN(rstN), .rxErrCnt(rxErrCnt), .txErrCnt(txErrCnt),
    .bitStrobe(bitStrobe), .busRecessive(busRecessive), .recoverHold(recoverHold),
    .evtEnable(evtEnable), .mode(mode), .warnFlag(warnFlag), .txPassive(txPassive),
    .rxPassive(rxPassive), .evtPulse(evtPulse), .clearCounters(clearCounters)
  );

  // reference model built from the requirements: 0 active,1 passive,2 off,3 clearing
  int mSt = 0, mRun = 0, mOcc = 0;
  logic [3:0] mPrev = '0;
  logic [1:0] eMode = '0;
  logic eWarn = 0, eTxP = 0, eRxP = 0, eClr = 0;
  logic [4:0] ePulse = '0;

  function automatic int nextState(int st, int rx, int tx, int occ, bit hold);
    if (st == 0 || st == 1) begin
      if (tx >= 256) return 2;
      if (tx >= 128 || rx >= 128) return 1;
      return 0;
    end
    if (st == 2) return (occ == 128 && !hold) ? 3 : 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mRun = 0; mOcc = 0; mPrev = '0; eMode = '0;
      eWarn = 0; eTxP = 0; eRxP = 0; eClr = 0; ePulse = '0;
    end else begin
      logic [3:0] lv;
      int nx;
      lv = {rxErrCnt >= 128, txErrCnt >= 128, rxErrCnt >= 96, txErrCnt >= 96};
      nx = nextState(mSt, rxErrCnt, txErrCnt, mOcc, recoverHold);
      if (mSt == 2) begin
        if (bitStrobe) begin
          if (!busRecessive) mRun = 0;
          else if (mRun == 10) begin mRun = 0; if (mOcc < 128) mOcc++; end
          else mRun++;
        end
      end else begin
        mRun = 0; mOcc = 0;
      end
      ePulse[3:0] = lv & ~mPrev & evtEnable[3:0];
      ePulse[4] = evtEnable[4] && nx == 2 && mSt != 2;
      mPrev = lv;
      eWarn = lv[0] | lv[1];
      eTxP = lv[2];
      eRxP = lv[3];
      eClr = (nx == 3);
      eMode = (nx == 3) ? 2'd2 : 2'(nx);
      mSt = nx;
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    string mtag;
    case (mSt)
      0: mtag = "R2";
      1: mtag = "R3";
      2: mtag = "R5";
      default: mtag = "R6";
    endcase
    chk(mtag, mode, eMode);
    chk("R8", warnFlag, eWarn);
    chk("R9 tx", txPassive, eTxP);
    chk("R9 rx", rxPassive, eRxP);
    chk("R10", evtPulse, ePulse);
    chk("R6 clr", clearCounters, eClr);
  endtask

  // set inputs just after a falling edge, then check at the next falling edge
  task automatic cyc(int rx, int tx, bit stb, bit rec, bit hold, logic [4:0] en);
    rxErrCnt = 9'(rx); txErrCnt = 9'(tx);
    bitStrobe = stb; busRecessive = rec; recoverHold = hold; evtEnable = en;
    @(negedge clk);
    checkAll();
  endtask

  function automatic int bandPick(int r);
    case (r % 6)
      0: return 94 + (r / 6) % 5;
      1: return 126 + (r / 6) % 5;
      2: return (r / 6) % 90;
      3: return 97 + (r / 6) % 30;
      4: return 130 + (r / 6) % 120;
      default: return 0;
    endcase
  endfunction

  task automatic recovery(int holdCycles);
    int tx = 300, rx = 50;
    for (int i = 0; i < 20000 && !(mSt == 0 && !clearCounters); i++) begin
      bit stb = ($urandom % 4) != 0;
      bit rec = ($urandom % 40) != 0;
      bit hold = i < holdCycles;
      if (mSt == 2 && mOcc == 128 && hold)
        chk("R7", mode, 2);
      if (eClr) begin tx = 0; rx = 0; end
      else if (mSt == 2) begin tx = $urandom % 512; rx = $urandom % 512; end
      cyc(rx, tx, stb, rec, hold, '1);
    end
    chk("R6 back", mode, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk("R1 mode", mode, 0);
    chk("R1 flags", {warnFlag, txPassive, rxPassive, clearCounters}, 0);
    chk("R1 pulse", evtPulse, 0);
    rstN = 1'b1;
    cyc(0, 0, 0, 1, 0, '1);
    chk("R2", mode, 0);

    // directed: receive count alone, even very high, only reaches passive
    cyc(300, 0, 0, 1, 0, '1);
    chk("R4 rx only", mode, 1);
    chk("R10 rx pulses", evtPulse, 5'b01010);
    cyc(300, 0, 0, 1, 0, '1);
    chk("R10 no repeat", evtPulse, 0);
    cyc(0, 0, 0, 1, 0, '1);
    chk("R2 back", mode, 0);

    // directed: masked rise gives no pulse
    cyc(0, 200, 0, 1, 0, 5'b00000);
    chk("R11 masked", evtPulse, 0);
    chk("R3 tx", mode, 1);
    cyc(0, 0, 0, 1, 0, '1);

    // random threshold traffic, tx kept under 256
    for (int i = 0; i < 600; i++) begin
      int rx = bandPick($urandom % 600);
      int tx = bandPick($urandom % 600);
      if ($urandom % 10 == 0) rx = 256 + $urandom % 256;
      cyc(rx, tx, $urandom % 2, $urandom % 2, 0, 5'($urandom));
    end
    cyc(0, 0, 0, 1, 0, '1);
    cyc(0, 0, 0, 1, 0, '1);

    // bus-off entry and recovery without hold
    cyc(10, 256, 0, 1, 0, '1);
    chk("R4 off", mode, 2);
    chk("R12 entry", evtPulse[4], 1);
    recovery(0);

    // recovery with the hold kept long past completion
    cyc(0, 511, 1, 1, 0, '1);
    chk("R4 off2", mode, 2);
    recovery(6000);

    // a few more random excursions including bus-off
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 100; i++)
        cyc(bandPick($urandom % 600), bandPick($urandom % 600), 0, 1, 0, 5'($urandom));
      cyc(0, 260 + $urandom % 200, 0, 1, 0, '1);
      recovery($urandom % 2 ? 0 : 3000);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule